// File: doc/BRIEF.md
# Uncorrectable Error Status Logger

This block keeps the uncorrectable error status and mask registers of one switch port. Link, transaction and memory logic send single-cycle event pulses, one wire per status bit position. Each supported event sets a sticky status bit that software clears by writing a one to it. The block also holds a five-bit pointer to the first unmasked error, and it raises a one-cycle report toward the root complex when an unmasked error is newly recorded.

The mask changes only what happens around an error: logging in the pointer and reporting. It never stops the status bit from latching. A double-bit memory error is recorded only while a separate reporting enable input is high, and its status bit reads as zero while that enable is low.

Software reaches both registers through a one-bit select, a write strobe, write data and a combinational read bus. Two resets are provided. A cold reset clears every register. A warm reset leaves the sticky state untouched and clears only the report pulse.

Top module: `uerr_status_logger`

## Requirements
- R1: Status bits 4 (data link protocol), 16 (unexpected completion), 17 (receiver overflow), 18 (malformed packet), 19 (ECRC) and 20 (unsupported request) reset to 0. Each is set in the cycle after a pulse on the matching `evt_i` bit, and it stays set until it is cleared.
- R2: A write with `reg_sel`=0 clears every status bit where `reg_wdata` is 1 and leaves the bits where it is 0 unchanged. When an event and a clear hit the same bit in the same cycle, the bit stays set.
- R3: All status bits other than 4, 16–20 and 31 read as 0 and ignore both events and writes. This includes 14, 15, 21 and 22–30.
- R4: Status bit 31 (double-bit error) sets on `evt_i[31]` only while `dbe_rpt_en`=1. While `dbe_rpt_en`=0 it reads as 0. It is cleared by a write of 1 at any time.
- R5: A set mask bit never prevents the matching status bit from setting.
- R6: Reading with `reg_sel`=1 returns the mask register. Bits 0, 4, 16–20 and 31 are read/write and reset to 0. All other mask bits read as 0 and ignore writes.
- R7: `err_report_o` is high for exactly the one cycle after a cycle in which at least one unmasked event found its status bit clear. A masked event, or an event on a bit that is already set, produces no report.
- R8: `fep_o` resets to 0. When unmasked events arrive and the status bit that `fep_o` points to is clear, `fep_o` takes the lowest index among those events. Otherwise it holds.
- R9: `cold_rst` clears the status bits, mask bits, pointer and report. `warm_rst` clears only the report and leaves the status, mask and pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst | input | 1 | Synchronous power-on reset that clears all state |
| warm_rst | input | 1 | Synchronous normal reset that spares sticky state |
| evt_i | input | 32 | Error event pulses, one per status bit position |
| dbe_rpt_en | input | 1 | Enables recording of double-bit memory errors |
| reg_sel | input | 1 | Register select: 0 status, 1 mask |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| fep_o | output | 5 | First-error pointer |
| err_report_o | output | 1 | One-cycle error report pulse |

## Verification
The main sweep steps through all 128 combinations of the seven recordable events. Each step uses a mask pattern derived from the step index, toggles the double-bit enable and applies a partial clear. Comparing against an arithmetic model separates three things: the latching of status bits, the masking of the report, and the pointer update. Single-event sweeps across all 32 positions separate implemented bits from hardwired ones.

Directed sequences cover four more cases:
- an event and a clear landing on the same bit in the same cycle;
- a pointer held by a still-set bit;
- the double-bit bit hidden and then revealed by the enable;
- the difference between warm and cold reset.

// File: rtl/uerr_pkg.sv
package uerr_pkg;

    localparam int REG_W = 32;
    localparam int PTR_W = $clog2(REG_W);

    // Status bits that latch events: 4, 16..20, 31
    localparam logic [REG_W-1:0] ST_IMPL   = 32'h801F_0010;
    // Mask bits that hold state: the above plus the spare bit 0
    localparam logic [REG_W-1:0] MASK_IMPL = 32'h801F_0011;
    localparam int DBE_BIT = 31;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_MASK   = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic              wr;
        reg_sel_e          sel;
        logic [REG_W-1:0]  wdata;
    } reg_req_t;

    typedef struct packed {
        logic [REG_W-1:0] eff;      // events that may set status
        logic [REG_W-1:0] unmasked; // effective and not masked
        logic [REG_W-1:0] fresh;    // unmasked and status was clear
    } evt_class_t;

    function automatic logic [PTR_W-1:0] lowest_index(input logic [REG_W-1:0] v);
        logic [PTR_W-1:0] idx;
        idx = '0;
        for (int i = REG_W - 1; i >= 0; i--) begin
            if (v[i]) idx = PTR_W'(i);
        end
        return idx;
    endfunction

endpackage

// File: rtl/uerr_event_filter.sv
module uerr_event_filter
    import uerr_pkg::*;
#(
    parameter logic [REG_W-1:0] IMPL    = ST_IMPL,
    parameter bit               HAS_DBE = 1'b1
) (
    input  logic [REG_W-1:0] evt,
    input  logic             dbe_en,
    input  logic [REG_W-1:0] mask_q,
    input  logic [REG_W-1:0] status_q,
    output evt_class_t       cls
);
    logic [REG_W-1:0] gate;

    generate
        if (HAS_DBE) begin : g_dbe
            always_comb begin
                gate          = IMPL;
                gate[DBE_BIT] = IMPL[DBE_BIT] & dbe_en;
            end
        end else begin : g_nodbe
            always_comb begin
                gate          = IMPL;
                gate[DBE_BIT] = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        cls.eff      = evt & gate;
        cls.unmasked = cls.eff & ~mask_q;
        cls.fresh    = cls.unmasked & ~status_q;
    end

endmodule

// File: rtl/uerr_status_bank.sv
module uerr_status_bank
    import uerr_pkg::*;
#(
    parameter logic [REG_W-1:0] IMPL = ST_IMPL
) (
    input  logic             clk,
    input  logic             cold_rst,
    input  logic [REG_W-1:0] set_vec,
    input  logic [REG_W-1:0] clr_vec,
    output logic [REG_W-1:0] status_q
);
    logic [REG_W-1:0] nxt;

    // A set wins over a clear landing in the same cycle
    always_comb nxt = (set_vec | (status_q & ~clr_vec)) & IMPL;

    always_ff @(posedge clk) begin
        if (cold_rst) status_q <= '0;
        else          status_q <= nxt;
    end

endmodule

// File: rtl/uerr_mask_bank.sv
module uerr_mask_bank
    import uerr_pkg::*;
#(
    parameter logic [REG_W-1:0] IMPL = MASK_IMPL
) (
    input  logic             clk,
    input  logic             cold_rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] mask_q
);
    always_ff @(posedge clk) begin
        if (cold_rst)   mask_q <= '0;
        else if (wr_en) mask_q <= wdata & IMPL;
    end

endmodule

// File: rtl/uerr_first_ptr.sv
module uerr_first_ptr
    import uerr_pkg::*;
(
    input  logic             clk,
    input  logic             cold_rst,
    input  logic [REG_W-1:0] status_q,
    input  logic [REG_W-1:0] unmasked,
    output logic [PTR_W-1:0] fep_q
);
    logic pointed_live;

    always_comb pointed_live = status_q[fep_q];

    always_ff @(posedge clk) begin
        if (cold_rst)
            fep_q <= '0;
        else if ((|unmasked) && !pointed_live)
            fep_q <= lowest_index(unmasked);
    end

endmodule

// File: rtl/uerr_status_logger.sv
module uerr_status_logger
    import uerr_pkg::*;
(
    input  logic                clk,
    input  logic                cold_rst,
    input  logic                warm_rst,
    input  logic [REG_W-1:0]    evt_i,
    input  logic                dbe_rpt_en,
    input  logic                reg_sel,
    input  logic                reg_wr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    output logic [PTR_W-1:0]    fep_o,
    output logic                err_report_o
);
    reg_req_t          req;
    evt_class_t        cls;
    logic [REG_W-1:0]  status_q;
    logic [REG_W-1:0]  mask_q;
    logic [REG_W-1:0]  clr_vec;
    logic [REG_W-1:0]  status_view;
    logic              report_q;

    always_comb begin
        req.wr    = reg_wr;
        req.sel   = reg_sel_e'(reg_sel);
        req.wdata = reg_wdata;
    end

    always_comb clr_vec = (req.wr && req.sel == SEL_STATUS) ? req.wdata : '0;

    uerr_event_filter #(.IMPL(ST_IMPL), .HAS_DBE(1'b1)) u_filter (
        .evt      (evt_i),
        .dbe_en   (dbe_rpt_en),
        .mask_q   (mask_q),
        .status_q (status_q),
        .cls      (cls)
    );

    uerr_status_bank #(.IMPL(ST_IMPL)) u_status (
        .clk      (clk),
        .cold_rst (cold_rst),
        .set_vec  (cls.eff),
        .clr_vec  (clr_vec),
        .status_q (status_q)
    );

    uerr_mask_bank #(.IMPL(MASK_IMPL)) u_mask (
        .clk      (clk),
        .cold_rst (cold_rst),
        .wr_en    (req.wr && req.sel == SEL_MASK),
        .wdata    (req.wdata),
        .mask_q   (mask_q)
    );

    uerr_first_ptr u_fep (
        .clk      (clk),
        .cold_rst (cold_rst),
        .status_q (status_q),
        .unmasked (cls.unmasked),
        .fep_q    (fep_o)
    );

    always_ff @(posedge clk) begin
        if (cold_rst || warm_rst) report_q <= 1'b0;
        else                      report_q <= |cls.fresh;
    end

    // Double-bit status stays stored but is hidden while its enable is low
    always_comb begin
        status_view          = status_q;
        status_view[DBE_BIT] = status_q[DBE_BIT] & dbe_rpt_en;
    end

    always_comb reg_rdata    = (req.sel == SEL_MASK) ? mask_q : status_view;
    always_comb err_report_o = report_q;

endmodule

// File: rtl/uerr_status_logger_chk.sv
module uerr_status_logger_chk
    import uerr_pkg::*;
(
    input logic             clk,
    input logic             cold_rst,
    input logic             warm_rst,
    input logic [REG_W-1:0] evt_i,
    input logic             dbe_rpt_en,
    input logic             reg_sel,
    input logic             reg_wr,
    input logic [REG_W-1:0] reg_wdata,
    input logic [REG_W-1:0] reg_rdata,
    input logic [PTR_W-1:0] fep_o,
    input logic             err_report_o,
    input logic [REG_W-1:0] status_q,
    input logic [REG_W-1:0] mask_q
);
    logic [REG_W-1:0] chk_eff;
    always_comb begin
        chk_eff          = evt_i & ST_IMPL;
        chk_eff[DBE_BIT] = evt_i[DBE_BIT] & dbe_rpt_en;
    end

    // R1 and R5: an accepted event is latched whatever the mask holds
    a_r1_event_sets: assert property (@(posedge clk) disable iff (cold_rst)
        (chk_eff != '0) |=> ((status_q & $past(chk_eff)) == $past(chk_eff)));

    a_r2_w1c_clears: assert property (@(posedge clk) disable iff (cold_rst)
        (reg_wr && !reg_sel && evt_i == '0) |=> ((status_q & $past(reg_wdata)) == '0));

    a_r3_unused_read_zero: assert property (@(posedge clk) disable iff (cold_rst)
        (!reg_sel) |-> ((reg_rdata & ~ST_IMPL) == '0));

    a_r4_dbe_hidden: assert property (@(posedge clk) disable iff (cold_rst)
        (!reg_sel && !dbe_rpt_en) |-> !reg_rdata[DBE_BIT]);

    a_r6_mask_unused_zero: assert property (@(posedge clk) disable iff (cold_rst)
        reg_sel |-> ((reg_rdata & ~MASK_IMPL) == '0));

    a_r7_report_cause: assert property (@(posedge clk) disable iff (cold_rst)
        err_report_o |-> $past((chk_eff & ~mask_q & ~status_q) != '0));

    a_r8_fep_hold: assert property (@(posedge clk) disable iff (cold_rst)
        status_q[fep_o] |=> $stable(fep_o));

    a_r9_warm_keeps: assert property (@(posedge clk) disable iff (cold_rst)
        (warm_rst && !reg_wr) |=> ($stable(mask_q) && $stable(fep_o)));

    a_r9_warm_quiet: assert property (@(posedge clk) disable iff (cold_rst)
        warm_rst |=> !err_report_o);

endmodule

bind uerr_status_logger uerr_status_logger_chk u_chk (
    .clk          (clk),
    .cold_rst     (cold_rst),
    .warm_rst     (warm_rst),
    .evt_i        (evt_i),
    .dbe_rpt_en   (dbe_rpt_en),
    .reg_sel      (reg_sel),
    .reg_wr       (reg_wr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .fep_o        (fep_o),
    .err_report_o (err_report_o),
    .status_q     (status_q),
    .mask_q       (mask_q)
);

// File: tb/uerr_status_logger_test.sv
`timescale 1ns/1ps
module uerr_status_logger_test;

    localparam logic [31:0] M_ST   = 32'h801F_0010; // bits 4,16..20,31
    localparam logic [31:0] M_MASK = 32'h801F_0011; // plus bit 0

    logic        clk = 1'b0;
    logic        cold_rst = 1'b1;
    logic        warm_rst = 1'b0;
    logic [31:0] evt_i = '0;
    logic        dbe_rpt_en = 1'b1;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [4:0]  fep_o;
    logic        err_report_o;

    int n_run  = 0;
    int n_fail = 0;

    logic [31:0] m_st   = '0;
    logic [31:0] m_mask = '0;
    logic [4:0]  m_fep  = '0;
    logic        m_rep  = 1'b0;

    always #10 clk = ~clk;

    uerr_status_logger uut (
        .clk(clk), .cold_rst(cold_rst), .warm_rst(warm_rst), .evt_i(evt_i),
        .dbe_rpt_en(dbe_rpt_en), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fep_o(fep_o),
        .err_report_o(err_report_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [4:0] low_idx(input logic [31:0] v);
        for (int i = 0; i < 32; i++) if (v[i]) return 5'(i);
        return 5'd0;
    endfunction

    // Spread 7 bits onto the recordable positions 4,16,17,18,19,20,31
    function automatic logic [31:0] spread(input logic [6:0] p);
        logic [31:0] v;
        v = '0;
        v[4]  = p[0]; v[16] = p[1]; v[17] = p[2]; v[18] = p[3];
        v[19] = p[4]; v[20] = p[5]; v[31] = p[6];
        return v;
    endfunction

    function automatic logic [31:0] st_view();
        logic [31:0] v;
        v = m_st;
        if (!dbe_rpt_en) v[31] = 1'b0;
        return v;
    endfunction

    // One clock with the given stimulus; the model advances at the edge
    task automatic cycle(input logic [31:0] e, input logic wr, input logic sel,
                         input logic [31:0] wd);
        logic [31:0] eff, unm, clr;
        evt_i = e; reg_wr = wr; reg_sel = sel; reg_wdata = wd;
        @(posedge clk);
        eff = e & M_ST;
        if (!dbe_rpt_en) eff[31] = 1'b0;
        unm = eff & ~m_mask;
        m_rep = |(unm & ~m_st);
        if (unm != '0 && !m_st[m_fep]) m_fep = low_idx(unm);
        clr = (wr && !sel) ? wd : '0;
        m_st = ((m_st & ~clr) | eff) & M_ST;
        if (wr && sel) m_mask = wd & M_MASK;
        @(negedge clk);
        evt_i = '0; reg_wr = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [31:0] v);
        reg_sel = sel; #1; v = reg_rdata;
    endtask

    task automatic check_all(input string req);
        logic [31:0] v;
        rd(1'b0, v); check(req, "status", v, st_view());
        rd(1'b1, v); check(req, "mask", v, m_mask);
        check(req, "fep", {27'd0, fep_o}, {27'd0, m_fep});
        check(req, "report", {31'd0, err_report_o}, {31'd0, m_rep});
    endtask

    initial begin
        #(20ns * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        cold_rst = 1'b0;
        // R9 reset state
        check_all("R9");

        // R1 R3 R7 R8: single events on every position, then clear
        for (int k = 0; k < 32; k++) begin
            cycle(32'd1 << k, 1'b0, 1'b0, '0);
            check_all(M_ST[k] ? "R1" : "R3");
            cycle('0, 1'b1, 1'b0, 32'hFFFF_FFFF);
            check_all("R2");
        end

        // R3: writes of ones to an empty register and all events at once
        cycle('0, 1'b1, 1'b0, 32'hFFFF_FFFF);
        check_all("R3");
        cycle(32'hFFFF_FFFF, 1'b0, 1'b0, '0);
        rd(1'b0, v); check("R3", "all events", v, M_ST);
        check_all("R8");

        // R2: event and clear on bit 17 in the same cycle; writing 0 keeps
        cycle(32'h0002_0000, 1'b1, 1'b0, 32'h0002_0000);
        rd(1'b0, v); check("R2", "event beats clear", v[17], 1'b1);
        cycle('0, 1'b1, 1'b0, 32'h0000_0000);
        rd(1'b0, v); check("R2", "write zero keeps", v, M_ST);
        cycle('0, 1'b1, 1'b0, 32'hFFFF_FFFF);
        check_all("R2");

        // R6: mask write of all ones
        cycle('0, 1'b1, 1'b1, 32'hFFFF_FFFF);
        rd(1'b1, v); check("R6", "mask readback", v, M_MASK);
        // R5 R7 R8: fully masked events still set status, no report
        cycle(32'h801F_0010, 1'b0, 1'b0, '0);
        rd(1'b0, v); check("R5", "masked sets", v, M_ST);
        check("R7", "masked no report", {31'd0, err_report_o}, 32'd0);
        check_all("R8");
        cycle('0, 1'b1, 1'b0, 32'hFFFF_FFFF);
        cycle('0, 1'b1, 1'b1, 32'h0);

        // R8: lowest wins, then held while pointed bit is set
        cycle(32'h0005_0000, 1'b0, 1'b0, '0);
        check("R8", "lowest wins", {27'd0, fep_o}, 32'd16);
        cycle(32'h0000_0010, 1'b0, 1'b0, '0);
        check("R8", "held", {27'd0, fep_o}, 32'd16);
        check("R7", "new bit reports", {31'd0, err_report_o}, 32'd1);
        cycle(32'h0000_0010, 1'b0, 1'b0, '0);
        check("R7", "already set no report", {31'd0, err_report_o}, 32'd0);
        cycle('0, 1'b1, 1'b0, 32'h0001_0000);
        cycle(32'h0008_0000, 1'b0, 1'b0, '0);
        check("R8", "moves after clear", {27'd0, fep_o}, 32'd19);
        cycle('0, 1'b1, 1'b0, 32'hFFFF_FFFF);

        // R4: double-bit gating
        dbe_rpt_en = 1'b0;
        cycle(32'h8000_0000, 1'b0, 1'b0, '0);
        dbe_rpt_en = 1'b1;
        rd(1'b0, v); check("R4", "ignored when off", v[31], 1'b0);
        cycle(32'h8000_0000, 1'b0, 1'b0, '0);
        rd(1'b0, v); check("R4", "set when on", v[31], 1'b1);
        dbe_rpt_en = 1'b0;
        rd(1'b0, v); check("R4", "hidden", v[31], 1'b0);
        dbe_rpt_en = 1'b1;
        rd(1'b0, v); check("R4", "revealed", v[31], 1'b1);
        dbe_rpt_en = 1'b0;
        cycle('0, 1'b1, 1'b0, 32'h8000_0000);
        dbe_rpt_en = 1'b1;
        rd(1'b0, v); check("R4", "cleared while hidden", v[31], 1'b0);

        // R1 R5 R7 R8: sweep of all event combinations
        for (int p = 0; p < 128; p++) begin
            logic [6:0] pp;
            pp = 7'(p);
            dbe_rpt_en = pp[3] ^ pp[0];
            cycle('0, 1'b1, 1'b1, spread(7'(p * 37)) | {31'd0, pp[2]});
            cycle(spread(pp), 1'b0, 1'b0, '0);
            check_all("R1");
            cycle('0, 1'b1, 1'b0, spread(7'(p ^ 85)));
            check_all("R7");
        end
        dbe_rpt_en = 1'b1;

        // R9: warm keeps sticky state, cold clears it
        cycle('0, 1'b1, 1'b1, 32'h0000_0011);
        cycle(32'h0010_0010, 1'b0, 1'b0, '0);
        warm_rst = 1'b1;
        @(posedge clk); m_rep = 1'b0;
        @(negedge clk); warm_rst = 1'b0;
        check_all("R9");
        cold_rst = 1'b1;
        @(posedge clk); m_st = '0; m_mask = '0; m_fep = '0; m_rep = 1'b0;
        @(negedge clk); cold_rst = 1'b0;
        check_all("R9");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule